// File: doc/BRIEF.md
# Ring-Buffer Flash Programming Engine

This block is a bus-master sequencer. It takes 32-bit words out of a circular buffer in shared memory and programs each one into flash through the register window of a flash controller. The controller has registers for write enable, target address, write command, write data and status. Software sets up the buffer and pulses `start` with five job values: the controller base address, a word count, the buffer bounds and the first flash target. The engine then runs without further help. When the job ends it pulses `done`, and it raises `error` in the same cycle if the job failed.

The first two words of the buffer are control words. The word at the buffer start is the producer's fill pointer. The word four bytes above it is the engine's drain pointer. Data slots begin eight bytes above the start and stop just below the end address. The engine treats a fill pointer of zero as an abort. It tells the producer about a failure by writing zero into the drain pointer. Every memory and register access goes through one request/acknowledge master port, and only one transaction is outstanding at any time.

Top module: `ringbuf_flash_writer`

## Requirements
- R1: On `start` in idle, the engine latches the job inputs and clears the reported status. Its first bus access writes 1 to the write-control register at base+0x08.
- R2: Each loop first reads the fill pointer at buffer start. If that value is zero, the job ends with `done` and `error` low. `final_status` then holds the last controller status value read since start, or zero if none was read. `final_addr` holds the next target address.
- R3: After reading the fill pointer, the engine reads the drain pointer at buffer start+4. While the two are equal it keeps polling and issues no flash command.
- R4: For each word, the engine writes the target address to base+0x10, then writes 1 to the command register at base+0x0C, then reads status at base+0x1C. If status bit 1 (locked) or bit 2 (bad address) is set, it takes the error path.
- R5: The error path writes zero to buffer start+4. It then pulses `done` with `error` high. `final_status` holds the status value that failed, and `final_addr` holds the target of the failing word.
- R6: On a clean check, the engine polls status until bit 3 (ready) is set. It then reads the data word at the drain pointer, writes it to base+0x18 and writes 8 to base+0x0C. After that it polls status until bit 0 (busy) is clear.
- R7: After each word the drain pointer advances by 4. When it reaches or passes the buffer end, it wraps to buffer start+8. The new drain pointer is written to buffer start+4 once busy has cleared.
- R8: The count decrements after each stored drain pointer. The job ends with `done` and `error` low when the count reaches zero. `final_addr` then equals the first target plus 4 times the count.
- R9: The master port holds `m_req`, `m_we`, `m_addr` and `m_wdata` stable from the rise of `m_req` until the cycle `m_ack` is seen. A new request is raised only after the previous one has completed.
- R10: After reset, `done`, `error` and `m_req` are low. `done` lasts exactly one cycle, and `error` is high only in a cycle where `done` is high.
- R11: A `start` pulse while a job is running is ignored. The running job keeps its latched inputs, and no second `done` follows.
- R12: A job started with a word count of zero performs only the write-enable access and then ends with `done` and `error` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Job start pulse, taken only in idle |
| ctrl_base | input | 32 | Flash controller register window base |
| word_count | input | 16 | Number of words to program |
| ring_lo | input | 32 | Buffer start (fill pointer word) |
| ring_hi | input | 32 | Buffer end, exclusive |
| flash_addr | input | 32 | First flash target address |
| done | output | 1 | One-cycle end-of-job pulse |
| error | output | 1 | Failure flag, high only with done |
| final_status | output | 32 | Last controller status read |
| final_addr | output | 32 | Failing target or next target |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write enable |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Master write data |
| m_ack | input | 1 | Slave acknowledge, one cycle per request |
| m_rdata | input | 32 | Read data, valid with m_ack |

## Verification
The assertions assume three things. First, `m_ack` comes only while `m_req` is high and lasts one cycle. Second, the buffer bounds leave at least one data slot. Third, the drain pointer the producer sets up lies inside the data area. The bench's memory and controller model acknowledges every request after a fixed delay and drops the acknowledge in the next cycle. Its producer writes only pointers inside the slot range and never fills the buffer beyond one slot short of full, so a full buffer is never confused with an empty one. The scoreboard checks the target and data of each programmed word against the order in which the producer queued them.

// File: rtl/rfw_pkg.sv
// Shared constants and state type for the ring-buffer flash programming engine.
// Assumes 32-bit words and byte addressing.
package rfw_pkg;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned HDR_BYTES  = 8;

    localparam int unsigned ST_BUSY_BIT  = 0;
    localparam int unsigned ST_LOCK_BIT  = 1;
    localparam int unsigned ST_BADA_BIT  = 2;
    localparam int unsigned ST_READY_BIT = 3;

    localparam int unsigned CMD_LOAD_ADDR = 1;
    localparam int unsigned CMD_PROGRAM   = 8;
    localparam int unsigned WREN_VALUE    = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_GET_WP,
        ST_GET_RP,
        ST_SET_ADDR,
        ST_LOAD,
        ST_CHK,
        ST_WAIT_RDY,
        ST_GET_DATA,
        ST_PUT_DATA,
        ST_PROG,
        ST_WAIT_BUSY,
        ST_PUT_RP,
        ST_FAIL_RP
    } seq_state_t;
endpackage

// File: rtl/rfw_bus_port.sv
// Single-outstanding request/acknowledge master.
// Takes a one-cycle command, holds the request stable until acknowledged,
// and returns a one-cycle response with the captured read data.
// Assumes m_ack is only asserted while m_req is high.
module rfw_bus_port #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_we,
    input  logic [AW-1:0] go_addr,
    input  logic [DW-1:0] go_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic [DW-1:0] m_rdata
);

    // Launch a request on go, retire it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_req     <= 1'b0;
            m_we      <= 1'b0;
            m_addr    <= '0;
            m_wdata   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (m_req) begin
                if (m_ack) begin
                    m_req     <= 1'b0;
                    rsp_valid <= 1'b1;
                    rsp_data  <= m_rdata;
                end
            end else if (go) begin
                m_req   <= 1'b1;
                m_we    <= go_we;
                m_addr  <= go_addr;
                m_wdata <= go_wdata;
            end
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (!m_req && !rsp_valid));

endmodule

// File: rtl/rfw_ring_step.sv
// Next-pointer logic: moves the drain pointer by one word with wrap
// into the data area, and moves the flash target by one word.
// Assumes ring_lo + HDR_BYTES < ring_hi.
module rfw_ring_step
    import rfw_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] tgt,
    input  logic [AW-1:0] ring_lo,
    input  logic [AW-1:0] ring_hi,
    output logic [AW-1:0] src_next,
    output logic [AW-1:0] tgt_next
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
    localparam logic [AW-1:0] HDR  = AW'(HDR_BYTES);

    logic [AW-1:0] src_inc;

    // Advance both pointers and fold the source back into the slot area.
    always_comb begin
        src_inc  = src + STEP;
        src_next = (src_inc >= ring_hi) ? (ring_lo + HDR) : src_inc;
        tgt_next = tgt + STEP;
    end
endmodule

// File: rtl/rfw_seq.sv
// Job sequencer: walks the fill/drain pointer protocol and the per-word
// controller handshake, one bus access per state.
// Assumes the bus port completes every request with one response.
module rfw_seq
    import rfw_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned CW        = 16,
    parameter int unsigned OFF_CTRL  = 8,
    parameter int unsigned OFF_CMD   = 12,
    parameter int unsigned OFF_ADDR  = 16,
    parameter int unsigned OFF_WDATA = 24,
    parameter int unsigned OFF_STAT  = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ctrl_base,
    input  logic [CW-1:0] word_count,
    input  logic [AW-1:0] ring_lo,
    input  logic [AW-1:0] ring_hi,
    input  logic [AW-1:0] flash_addr,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    input  logic [AW-1:0] src_next,
    input  logic [AW-1:0] tgt_next,
    output logic          go,
    output logic          go_we,
    output logic [AW-1:0] go_addr,
    output logic [DW-1:0] go_wdata,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] tgt_q,
    output logic [AW-1:0] lo_q,
    output logic [AW-1:0] hi_q,
    output logic [DW-1:0] status_q,
    output logic          done,
    output logic          error
);
    localparam logic [AW-1:0] RP_OFS = AW'(WORD_BYTES);
    localparam logic [AW-1:0] HDR    = AW'(HDR_BYTES);

    seq_state_t    state;
    logic          pend;
    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] wp_q;
    logic [DW-1:0] data_q;

    // A request is launched once per state, when none is in flight.
    assign go = (state != ST_IDLE) && !pend;

    // Address, direction and data of the access each state performs.
    always_comb begin
        go_we    = 1'b0;
        go_addr  = base_q + AW'(OFF_STAT);
        go_wdata = '0;
        unique case (state)
            ST_WREN:     begin go_we = 1'b1; go_addr = base_q + AW'(OFF_CTRL); go_wdata = DW'(WREN_VALUE); end
            ST_GET_WP:   go_addr = lo_q;
            ST_GET_RP:   go_addr = lo_q + RP_OFS;
            ST_SET_ADDR: begin go_we = 1'b1; go_addr = base_q + AW'(OFF_ADDR); go_wdata = DW'(tgt_q); end
            ST_LOAD:     begin go_we = 1'b1; go_addr = base_q + AW'(OFF_CMD); go_wdata = DW'(CMD_LOAD_ADDR); end
            ST_GET_DATA: go_addr = src_q;
            ST_PUT_DATA: begin go_we = 1'b1; go_addr = base_q + AW'(OFF_WDATA); go_wdata = data_q; end
            ST_PROG:     begin go_we = 1'b1; go_addr = base_q + AW'(OFF_CMD); go_wdata = DW'(CMD_PROGRAM); end
            ST_PUT_RP:   begin go_we = 1'b1; go_addr = lo_q + RP_OFS; go_wdata = DW'(src_q); end
            ST_FAIL_RP:  begin go_we = 1'b1; go_addr = lo_q + RP_OFS; go_wdata = '0; end
            default:     ;
        endcase
    end

    // State walk, job latches and end-of-job pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            src_q    <= '0;
            tgt_q    <= '0;
            wp_q     <= '0;
            data_q   <= '0;
            status_q <= '0;
            done     <= 1'b0;
            error    <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            if (go) pend <= 1'b1;
            if (state == ST_IDLE) begin
                if (start) begin
                    base_q   <= ctrl_base;
                    cnt_q    <= word_count;
                    lo_q     <= ring_lo;
                    hi_q     <= ring_hi;
                    tgt_q    <= flash_addr;
                    status_q <= '0;
                    state    <= ST_WREN;
                end
            end else if (rsp_valid) begin
                pend <= 1'b0;
                unique case (state)
                    ST_WREN: begin
                        if (cnt_q == '0) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_GET_WP;
                        end
                    end
                    ST_GET_WP: begin
                        wp_q <= rsp_data;
                        if (rsp_data == '0) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_GET_RP;
                        end
                    end
                    ST_GET_RP: begin
                        if (rsp_data == wp_q) begin
                            state <= ST_GET_WP;
                        end else begin
                            src_q <= AW'(rsp_data);
                            state <= ST_SET_ADDR;
                        end
                    end
                    ST_SET_ADDR: state <= ST_LOAD;
                    ST_LOAD:     state <= ST_CHK;
                    ST_CHK: begin
                        status_q <= rsp_data;
                        if (rsp_data[ST_LOCK_BIT] || rsp_data[ST_BADA_BIT])
                            state <= ST_FAIL_RP;
                        else
                            state <= ST_WAIT_RDY;
                    end
                    ST_WAIT_RDY: begin
                        status_q <= rsp_data;
                        if (rsp_data[ST_READY_BIT]) state <= ST_GET_DATA;
                    end
                    ST_GET_DATA: begin
                        data_q <= rsp_data;
                        state  <= ST_PUT_DATA;
                    end
                    ST_PUT_DATA: state <= ST_PROG;
                    ST_PROG: begin
                        src_q <= src_next;
                        tgt_q <= tgt_next;
                        state <= ST_WAIT_BUSY;
                    end
                    ST_WAIT_BUSY: begin
                        status_q <= rsp_data;
                        if (!rsp_data[ST_BUSY_BIT]) state <= ST_PUT_RP;
                    end
                    ST_PUT_RP: begin
                        cnt_q <= cnt_q - 1'b1;
                        if (cnt_q == CW'(1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_GET_WP;
                        end
                    end
                    ST_FAIL_RP: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        error <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> ($stable(base_q) && $stable(lo_q) && $stable(hi_q)));

    // R6
    data_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && go_we && go_addr == base_q + AW'(OFF_WDATA)) |-> status_q[ST_READY_BIT]);

    // R7
    rp_in_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUT_RP) |-> (src_q >= lo_q + HDR && src_q < hi_q));

endmodule

// File: rtl/ringbuf_flash_writer.sv
// Top of the ring-buffer flash programming engine: sequencer, pointer
// step logic and single-outstanding master port.
// Assumes the buffer holds at least one data slot and that the producer
// keeps the pointers word aligned and inside the slot area.
module ringbuf_flash_writer #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ctrl_base,
    input  logic [CW-1:0] word_count,
    input  logic [AW-1:0] ring_lo,
    input  logic [AW-1:0] ring_hi,
    input  logic [AW-1:0] flash_addr,
    output logic          done,
    output logic          error,
    output logic [DW-1:0] final_status,
    output logic [AW-1:0] final_addr,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic [DW-1:0] m_rdata
);
    logic          go;
    logic          go_we;
    logic [AW-1:0] go_addr;
    logic [DW-1:0] go_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] src_q;
    logic [AW-1:0] tgt_q;
    logic [AW-1:0] lo_q;
    logic [AW-1:0] hi_q;
    logic [AW-1:0] src_next;
    logic [AW-1:0] tgt_next;

    rfw_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ctrl_base  (ctrl_base),
        .word_count (word_count),
        .ring_lo    (ring_lo),
        .ring_hi    (ring_hi),
        .flash_addr (flash_addr),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .src_next   (src_next),
        .tgt_next   (tgt_next),
        .go         (go),
        .go_we      (go_we),
        .go_addr    (go_addr),
        .go_wdata   (go_wdata),
        .src_q      (src_q),
        .tgt_q      (tgt_q),
        .lo_q       (lo_q),
        .hi_q       (hi_q),
        .status_q   (final_status),
        .done       (done),
        .error      (error)
    );

    rfw_ring_step #(.AW(AW)) u_step (
        .src      (src_q),
        .tgt      (tgt_q),
        .ring_lo  (lo_q),
        .ring_hi  (hi_q),
        .src_next (src_next),
        .tgt_next (tgt_next)
    );

    rfw_bus_port #(.AW(AW), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_we     (go_we),
        .go_addr   (go_addr),
        .go_wdata  (go_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_ack     (m_ack),
        .m_rdata   (m_rdata)
    );

    assign final_addr = tgt_q;

endmodule

// File: tb/ringbuf_flash_writer_test.sv
// Bench: memory plus controller model behind the master port, a producer
// task that queues expected programs, and a scoreboard in the model.
module ringbuf_flash_writer_test;
    localparam logic [31:0] CTRL = 32'h4000_0000;
    localparam logic [31:0] LO   = 32'h0000_2000;
    localparam logic [31:0] HI   = 32'h0000_2018;
    localparam int ACK_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctrl_base = CTRL;
    logic [15:0] word_count = '0;
    logic [31:0] ring_lo = LO;
    logic [31:0] ring_hi = HI;
    logic [31:0] flash_addr = '0;
    logic        done, error;
    logic [31:0] final_status, final_addr;
    logic        m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic        m_ack;
    logic [31:0] m_rdata;

    ringbuf_flash_writer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_base(ctrl_base),
        .word_count(word_count), .ring_lo(ring_lo), .ring_hi(ring_hi),
        .flash_addr(flash_addr), .done(done), .error(error),
        .final_status(final_status), .final_addr(final_addr),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_rdata(m_rdata)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Model state
    bit   [31:0] mem [int unsigned];
    logic [63:0] exp_q [$];
    logic [31:0] f_addr = '0, f_wdata = '0;
    logic [31:0] lock_addr = 32'hFFFF_FFF0, flash_limit = 32'hFFFF_0000;
    int rdy_n = 2, busy_n = 2, rdy_cnt = 0, busy_cnt = 0, wcnt = 0;
    bit rdy_armed = 0, ready_seen = 0, lock_flag = 0, bad_flag = 0;
    int acc_cnt = 0, prog_cnt = 0, done_cnt = 0, r9_viol = 0;
    logic        first_we;
    logic [31:0] first_addr, first_data;
    logic        prev_req = 0, prev_ack = 0;
    logic [31:0] prev_addr = '0;
    logic [31:0] pw;
    int cyc = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory, controller model and scoreboard monitor.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack   <= 1'b0;
            m_rdata <= '0;
        end else begin
            if (done) done_cnt++;
            if (prev_req && !prev_ack && !(m_req && m_addr == prev_addr)) r9_viol++;
            prev_req  = m_req;
            prev_ack  = m_ack;
            prev_addr = m_addr;
            if (m_req && !m_ack) begin
                if (wcnt < ACK_LAT) wcnt++;
                else begin
                    logic [31:0] st;
                    wcnt = 0;
                    m_ack <= 1'b1;
                    acc_cnt++;
                    if (acc_cnt == 1) begin
                        first_we = m_we; first_addr = m_addr; first_data = m_wdata;
                    end
                    if (m_we) begin
                        if (m_addr == CTRL + 32'h10) begin
                            f_addr = m_wdata; lock_flag = 0; bad_flag = 0;
                        end else if (m_addr == CTRL + 32'h0C) begin
                            if (m_wdata == 32'h1) begin
                                lock_flag = (f_addr == lock_addr);
                                bad_flag  = (f_addr >= flash_limit);
                                rdy_cnt = rdy_n; rdy_armed = 1; ready_seen = 0;
                            end else if (m_wdata == 32'h8) begin
                                prog_cnt++;
                                busy_cnt = busy_n;
                                if (exp_q.size() == 0)
                                    chk(0, "R4 unexpected program", f_addr, 32'h0);
                                else begin
                                    logic [63:0] e;
                                    e = exp_q.pop_front();
                                    chk(f_addr == e[63:32], "R4 program target", f_addr, e[63:32]);
                                    chk(f_wdata == e[31:0], "R6 program data", f_wdata, e[31:0]);
                                end
                            end
                        end else if (m_addr == CTRL + 32'h18) begin
                            f_wdata = m_wdata;
                            rdy_armed = 0;
                            chk(ready_seen, "R6 data after ready", {31'b0, ready_seen}, 32'h1);
                        end else if (m_addr == CTRL + 32'h08) begin
                        end else begin
                            mem[m_addr] = m_wdata;
                            if (m_addr == LO + 32'h4 && m_wdata != 0)
                                chk(busy_cnt == 0, "R6 busy cleared before pointer store", busy_cnt, 0);
                        end
                    end else if (m_addr == CTRL + 32'h1C) begin
                        st = 32'hA5A5_0000;
                        st[0] = (busy_cnt > 0);
                        if (busy_cnt > 0) busy_cnt--;
                        st[3] = rdy_armed && (rdy_cnt == 0);
                        if (rdy_cnt > 0) rdy_cnt--;
                        if (st[3]) ready_seen = 1;
                        st[1] = lock_flag;
                        st[2] = bad_flag;
                        m_rdata <= st;
                    end else begin
                        m_rdata <= rd(m_addr);
                    end
                end
            end else begin
                m_ack <= 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Producer: fill one slot, advance fill pointer, optionally queue expectation.
    task automatic put_word(input logic [31:0] data, input logic [31:0] tgt, input bit expect_prog);
        mem[pw] = data;
        if (expect_prog) exp_q.push_back({tgt, data});
        pw = pw + 4;
        if (pw >= HI) pw = LO + 8;
        mem[LO] = pw;
    endtask

    task automatic ring_reset();
        pw = LO + 8;
        mem[LO]     = pw;
        mem[LO + 4] = pw;
    endtask

    task automatic run_job(input logic [31:0] fa, input logic [15:0] cnt);
        @(negedge clk);
        flash_addr = fa;
        word_count = cnt;
        start = 1'b1;
        acc_cnt = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output bit err);
        seen = 0;
        err  = 0;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin
                seen = 1;
                err  = error;
                break;
            end
            @(negedge clk);
        end
        if (!seen) chk(0, "R10 done timeout", 0, 1);
        else begin
            @(negedge clk);
            chk(done == 1'b0, "R10 done one cycle", {31'b0, done}, 0);
        end
    endtask

    initial begin
        bit seen, err;
        int p0, a0, d0;
        repeat (3) @(negedge clk);
        chk(done == 0, "R10 reset done", {31'b0, done}, 0);
        chk(error == 0, "R10 reset error", {31'b0, error}, 0);
        chk(m_req == 0, "R9 reset request", {31'b0, m_req}, 0);
        rst_n = 1'b1;
        ring_reset();

        // R12: zero count
        run_job(32'h0000_0040, 16'd0);
        wait_done(seen, err);
        chk(err == 0, "R12 no error", {31'b0, err}, 0);
        chk(acc_cnt == 1, "R12 single access", acc_cnt, 1);
        chk(first_we && first_addr == CTRL + 32'h8, "R1 write-enable address", first_addr, CTRL + 32'h8);
        chk(first_data == 32'h1, "R1 write-enable value", first_data, 32'h1);
        chk(final_addr == 32'h40, "R12 final address", final_addr, 32'h40);

        // R4 R7 R8: three words, no wrap
        put_word(32'hDEAD_0001, 32'h100, 1);
        put_word(32'hDEAD_0002, 32'h104, 1);
        put_word(32'hDEAD_0003, 32'h108, 1);
        p0 = prog_cnt;
        run_job(32'h100, 16'd3);
        wait_done(seen, err);
        chk(first_addr == CTRL + 32'h8 && first_data == 1, "R1 first access", first_addr, CTRL + 32'h8);
        chk(err == 0, "R8 clean end", {31'b0, err}, 0);
        chk(final_addr == 32'h10C, "R8 final address", final_addr, 32'h10C);
        chk(rd(LO + 4) == LO + 32'h14, "R7 stored drain pointer", rd(LO + 4), LO + 32'h14);
        chk(prog_cnt - p0 == 3, "R8 program count", prog_cnt - p0, 3);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        // R7: wrap through buffer end
        put_word(32'hBEEF_0001, 32'h200, 1);
        put_word(32'hBEEF_0002, 32'h204, 1);
        put_word(32'hBEEF_0003, 32'h208, 1);
        run_job(32'h200, 16'd3);
        wait_done(seen, err);
        chk(err == 0, "R7 clean end", {31'b0, err}, 0);
        chk(rd(LO + 4) == LO + 32'h10, "R7 wrapped drain pointer", rd(LO + 4), LO + 32'h10);
        chk(final_addr == 32'h20C, "R8 final address after wrap", final_addr, 32'h20C);
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        // R3 then R2: empty ring polling, partial fill, abort
        p0 = prog_cnt;
        d0 = done_cnt;
        run_job(32'h300, 16'd4);
        a0 = acc_cnt;
        repeat (80) @(negedge clk);
        chk(prog_cnt == p0, "R3 no program while empty", prog_cnt - p0, 0);
        chk(done_cnt == d0, "R3 still running", done_cnt - d0, 0);
        chk(acc_cnt > a0 + 4, "R3 keeps polling", acc_cnt, a0 + 5);
        put_word(32'hCAFE_0001, 32'h300, 1);
        put_word(32'hCAFE_0002, 32'h304, 1);
        while (prog_cnt < p0 + 2) @(negedge clk);
        repeat (60) @(negedge clk);
        mem[LO] = 32'h0;
        wait_done(seen, err);
        chk(err == 0, "R2 abort without error", {31'b0, err}, 0);
        chk(final_status == 32'hA5A5_0000, "R2 last status read", final_status, 32'hA5A5_0000);
        chk(final_addr == 32'h308, "R2 next target", final_addr, 32'h308);
        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

        // R5: locked page on second word
        pw = rd(LO + 4);
        mem[LO] = pw;
        lock_addr = 32'h404;
        p0 = prog_cnt;
        put_word(32'h1111_0001, 32'h400, 1);
        put_word(32'h1111_0002, 32'h404, 0);
        run_job(32'h400, 16'd3);
        wait_done(seen, err);
        chk(err == 1, "R5 error flagged", {31'b0, err}, 1);
        chk(final_addr == 32'h404, "R5 failing target", final_addr, 32'h404);
        chk(final_status == 32'hA5A5_0002, "R5 failing status", final_status, 32'hA5A5_0002);
        chk(rd(LO + 4) == 0, "R5 drain pointer zeroed", rd(LO + 4), 0);
        chk(prog_cnt - p0 == 1, "R5 one word programmed", prog_cnt - p0, 1);
        lock_addr = 32'hFFFF_FFF0;

        // R4: bad address status bit
        ring_reset();
        flash_limit = 32'h1000;
        p0 = prog_cnt;
        put_word(32'h2222_0001, 32'h1000, 0);
        run_job(32'h1000, 16'd1);
        wait_done(seen, err);
        chk(err == 1, "R4 bad address error", {31'b0, err}, 1);
        chk(final_status == 32'hA5A5_0004, "R4 bad address status", final_status, 32'hA5A5_0004);
        chk(final_addr == 32'h1000, "R5 failing target", final_addr, 32'h1000);
        chk(prog_cnt == p0, "R4 nothing programmed", prog_cnt - p0, 0);
        flash_limit = 32'hFFFF_0000;

        // R11: start while running
        ring_reset();
        rdy_n = 6;
        busy_n = 6;
        put_word(32'h3333_0001, 32'h500, 1);
        put_word(32'h3333_0002, 32'h504, 1);
        run_job(32'h500, 16'd2);
        repeat (10) @(negedge clk);
        flash_addr = 32'h900;
        word_count = 16'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        d0 = done_cnt;
        wait_done(seen, err);
        chk(final_addr == 32'h508, "R11 first job kept", final_addr, 32'h508);
        chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
        repeat (40) @(negedge clk);
        chk(done_cnt - d0 == 1, "R11 single done", done_cnt - d0, 1);

        chk(r9_viol == 0, "R9 request held until acknowledge", r9_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule